// File: doc/BRIEF.md
# DRAM Row/Column/Bank Field Mapper

This block takes an address that is already local to one DRAM rank and splits it into the fields a DRAM command needs. These fields are the row, the column, the bank address and the bank group. The bits are picked from fixed, non-contiguous positions of the address, and those positions depend on the page policy. A close-page layout keeps the column in the low bits and sets the auto-precharge column bit. An open-page layout puts the column bits in a contiguous run. In open-page mode, a fine-grain bank option moves one column bit and one bank-group bit. An optional XOR hash folds higher address bits into the bank and bank-group fields, which spreads traffic across banks.

Each valid input comes with its own configuration: the page policy, the fine-grain flag, the XOR enable and the row and column bit counts. The decoded fields appear on the outputs one cycle later, together with a valid flag. The block is used after rank selection, to turn a rank address into DRAM coordinates, for example when reporting where a memory error occurred.

Top module: `dram_field_mapper`

## Requirements
- R1: `out_vld` is high in the cycle after a cycle with `in_vld` high, and low otherwise. When `in_vld` is low, the field outputs hold their previous values.
- R2: In close-page mode (`cfg_close_page`=1), row bit i is taken from address bit 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33,34 for i = 0..17 in that order.
- R3: In close-page mode, column bits 0..9 are taken from address bits 3,4,5,14,19,23,24,25,26,27 in that order, and `out_col[10]` (auto-precharge) is always 1.
- R4: In open-page mode, row bit i is taken from address bit 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33,34 for i = 0..17 in that order.
- R5: In open-page mode, column bit i is taken from address bit 3+i when `cfg_fine_bank`=0. When `cfg_fine_bank`=1 the sources are 3,4,5,7,8,9,10,11,12,13. `out_col[10]` is 0 in open-page mode.
- R6: Only the low `cfg_row_bits` row bits and the low `cfg_col_bits` column bits are filled, and the rest read 0 (apart from the auto-precharge bit). Row counts above 18 act as 18, and column counts above 10 act as 10.
- R7: In close-page mode, bank = {a[9],a[8]} and bank group = {a[7],a[6]}. When `cfg_bank_xor`=1, these are XORed with {a[28],a[22]} and {a[21],a[20]} respectively.
- R8: In open-page mode, bank = {a[19],a[18]} and bank group = {a[17],a[g]}, where g is 6 when fine-grain is on and 13 otherwise. When `cfg_bank_xor`=1, these are XORed with {a[23],a[22]} and {a[21],a[20]}.
- R9: After a synchronous reset (`rst_n` low at a clock edge), `out_vld` and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input address and configuration are valid |
| in_addr | input | 35 | Rank-local address |
| cfg_close_page | input | 1 | 1 = close-page layout, 0 = open-page layout |
| cfg_fine_bank | input | 1 | Fine-grain bank mode (open-page only) |
| cfg_bank_xor | input | 1 | Enable bank/bank-group XOR hashing |
| cfg_row_bits | input | 5 | Number of row bits (clamped to 18) |
| cfg_col_bits | input | 4 | Number of column bits (clamped to 10) |
| out_vld | output | 1 | Decoded fields valid |
| out_row | output | 18 | Row address |
| out_col | output | 11 | Column address, bit 10 = auto-precharge |
| out_bank | output | 2 | Bank address |
| out_bgrp | output | 2 | Bank group |

## Verification
The hardest behaviour to reach is a permutation slip, where two gather positions are swapped or a bit lands in the wrong place. Dense or random addresses hide this, because many source bits are set at once. The stimulus therefore uses mostly one-hot and two-hot addresses, and each one is chosen so that a single source bit lands in a single, known output position for one specific policy. All-ones addresses paired with small and oversized bit counts then cover the masking and clamping edges. XOR cases set a bank bit and its hash partner together, so the output cancels to zero, which a missing hash would not produce.

// File: rtl/dfm_pkg.sv
// dfm_pkg: widths and bit-gather position functions shared by the field mapper.
// Assumes a 35-bit rank address; positions are fixed by the DRAM layout.
package dfm_pkg;
    localparam int ADDR_W  = 35;
    localparam int POS_W   = 6;
    localparam int ROW_W   = 18;
    localparam int COL_W   = 10;   // gathered column bits
    localparam int COLO_W  = COL_W + 1; // plus auto-precharge bit
    localparam int RCNT_W  = 5;
    localparam int CCNT_W  = 4;

    // Source address bit for row bit i under the given page policy.
    function automatic logic [POS_W-1:0] row_pos(input logic close, input int i);
        int p;
        case (i)
            0:  p = close ? 15 : 14;
            1:  p = close ? 16 : 15;
            2:  p = close ? 17 : 16;
            3:  p = close ? 18 : 20;
            4:  p = close ? 20 : 28;
            5:  p = 21;
            6:  p = 22;
            7:  p = close ? 28 : 23;
            8:  p = close ? 10 : 24;
            9:  p = close ? 11 : 25;
            10: p = close ? 12 : 26;
            11: p = close ? 13 : 27;
            default: p = i + 17; // 12..17 -> 29..34
        endcase
        return POS_W'(p);
    endfunction

    // Source address bit for column bit i under policy and fine-grain mode.
    function automatic logic [POS_W-1:0] col_pos(input logic close, input logic fine,
                                                 input int i);
        int p;
        if (close) begin
            case (i)
                0, 1, 2: p = 3 + i;
                3:       p = 14;
                4:       p = 19;
                default: p = 18 + i; // 5..9 -> 23..27
            endcase
        end else if (fine) begin
            p = (i < 3) ? 3 + i : 4 + i;
        end else begin
            p = 3 + i;
        end
        return POS_W'(p);
    endfunction
endpackage

// File: rtl/dfm_gather.sv
// dfm_gather: collects OUT_W address bits from policy-dependent positions.
// Output bits at or above the (clamped) count are forced to zero.
// Assumes IS_ROW selects the row position set, otherwise the column set.
module dfm_gather #(
    parameter int OUT_W  = dfm_pkg::ROW_W,
    parameter int CNT_W  = dfm_pkg::RCNT_W,
    parameter bit IS_ROW = 1'b1
) (
    input  logic [dfm_pkg::ADDR_W-1:0] addr,
    input  logic                       close,
    input  logic                       fine,
    input  logic [CNT_W-1:0]           cnt,
    output logic [OUT_W-1:0]           bits
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(OUT_W);

    logic [CNT_W-1:0] cnt_eff;

    // Clamp the requested count to the field width.
    always_comb cnt_eff = (cnt > MAX_CNT) ? MAX_CNT : cnt;

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        logic [dfm_pkg::POS_W-1:0] pos;
        if (IS_ROW) begin : g_row
            assign pos = dfm_pkg::row_pos(close, i);
        end else begin : g_col
            assign pos = dfm_pkg::col_pos(close, fine, i);
        end
        // Pick the source bit and keep it only below the active count.
        assign bits[i] = addr[pos] & (CNT_W'(i) < cnt_eff);
    end
endmodule

// File: rtl/dfm_bank_hash.sv
// dfm_bank_hash: derives bank address and bank group from fixed address bits,
// optionally XOR-hashed with higher bits. Purely combinational.
module dfm_bank_hash (
    input  logic [dfm_pkg::ADDR_W-1:0] addr,
    input  logic                       close,
    input  logic                       fine,
    input  logic                       hash_en,
    output logic [1:0]                 bank,
    output logic [1:0]                 bgrp
);
    logic [1:0] bank_raw, bgrp_raw, bank_key, bgrp_key;

    // Select base and hash bits per page policy.
    always_comb begin
        if (close) begin
            bank_raw = {addr[9], addr[8]};
            bank_key = {addr[28], addr[22]};
            bgrp_raw = {addr[7], addr[6]};
        end else begin
            bank_raw = {addr[19], addr[18]};
            bank_key = {addr[23], addr[22]};
            bgrp_raw = {addr[17], fine ? addr[6] : addr[13]};
        end
        bgrp_key = {addr[21], addr[20]};
    end

    // Apply the optional hash.
    always_comb begin
        bank = hash_en ? (bank_raw ^ bank_key) : bank_raw;
        bgrp = hash_en ? (bgrp_raw ^ bgrp_key) : bgrp_raw;
    end
endmodule

// File: rtl/dram_field_mapper.sv
// dram_field_mapper: registers row/column/bank/bank-group fields decoded from
// a rank address one cycle after in_vld. Fields hold while in_vld is low.
// Assumes configuration is presented alongside each valid address.
module dram_field_mapper (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [dfm_pkg::ADDR_W-1:0]  in_addr,
    input  logic                        cfg_close_page,
    input  logic                        cfg_fine_bank,
    input  logic                        cfg_bank_xor,
    input  logic [dfm_pkg::RCNT_W-1:0]  cfg_row_bits,
    input  logic [dfm_pkg::CCNT_W-1:0]  cfg_col_bits,
    output logic                        out_vld,
    output logic [dfm_pkg::ROW_W-1:0]   out_row,
    output logic [dfm_pkg::COLO_W-1:0]  out_col,
    output logic [1:0]                  out_bank,
    output logic [1:0]                  out_bgrp
);
    import dfm_pkg::*;

    logic [ROW_W-1:0] row_d;
    logic [COL_W-1:0] col_d;
    logic [1:0]       bank_d, bgrp_d;

    dfm_gather #(.OUT_W(ROW_W), .CNT_W(RCNT_W), .IS_ROW(1'b1)) u_row (
        .addr(in_addr), .close(cfg_close_page), .fine(cfg_fine_bank),
        .cnt(cfg_row_bits), .bits(row_d)
    );

    dfm_gather #(.OUT_W(COL_W), .CNT_W(CCNT_W), .IS_ROW(1'b0)) u_col (
        .addr(in_addr), .close(cfg_close_page), .fine(cfg_fine_bank),
        .cnt(cfg_col_bits), .bits(col_d)
    );

    dfm_bank_hash u_bank (
        .addr(in_addr), .close(cfg_close_page), .fine(cfg_fine_bank),
        .hash_en(cfg_bank_xor), .bank(bank_d), .bgrp(bgrp_d)
    );

    // Output register: capture fields on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_row  <= '0;
            out_col  <= '0;
            out_bank <= '0;
            out_bgrp <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_row  <= row_d;
                out_col  <= {cfg_close_page, col_d};
                out_bank <= bank_d;
                out_bgrp <= bgrp_d;
            end
        end
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r1_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_row) && $stable(out_col)
                     && $stable(out_bank) && $stable(out_bgrp)));
    a_r3_autopre_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_close_page) |=> out_col[COL_W]);
    a_r5_autopre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !cfg_close_page) |=> !out_col[COL_W]);
    a_r6_zero_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_row_bits == '0) |=> out_row == '0);
endmodule

// File: tb/sim_dram_field_mapper.sv
module sim_dram_field_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [34:0] in_addr;
    logic        cfg_close_page, cfg_fine_bank, cfg_bank_xor;
    logic [4:0]  cfg_row_bits;
    logic [3:0]  cfg_col_bits;
    logic        out_vld;
    logic [17:0] out_row;
    logic [10:0] out_col;
    logic [1:0]  out_bank, out_bgrp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dram_field_mapper u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_addr(in_addr),
        .cfg_close_page(cfg_close_page), .cfg_fine_bank(cfg_fine_bank),
        .cfg_bank_xor(cfg_bank_xor), .cfg_row_bits(cfg_row_bits),
        .cfg_col_bits(cfg_col_bits), .out_vld(out_vld), .out_row(out_row),
        .out_col(out_col), .out_bank(out_bank), .out_bgrp(out_bgrp)
    );

    typedef struct packed {
        logic        close;
        logic        fine;
        logic        hx;
        logic [4:0]  rb;
        logic [3:0]  cb;
        logic [34:0] addr;
        logic [17:0] row;
        logic [10:0] col;
        logic [1:0]  bank;
        logic [1:0]  bg;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R2: close row bit 7 <- a28; R7 no hash
        '{1'b1, 1'b0, 1'b0, 5'd18, 4'd10, 35'h010000000, 18'h00080, 11'h400, 2'd0, 2'd0},
        // R7: close hash, a28 flips bank[1]
        '{1'b1, 1'b0, 1'b1, 5'd18, 4'd10, 35'h010000000, 18'h00080, 11'h400, 2'd2, 2'd0},
        // R8: open coarse, bank group[0] <- a13
        '{1'b0, 1'b0, 1'b0, 5'd18, 4'd10, 35'h000002000, 18'h00000, 11'h000, 2'd0, 2'd1},
        // R5: open fine, column bit 9 <- a13
        '{1'b0, 1'b1, 1'b0, 5'd18, 4'd10, 35'h000002000, 18'h00000, 11'h200, 2'd0, 2'd0},
        // R8/R5: open fine, a6 feeds bank group, not column
        '{1'b0, 1'b1, 1'b0, 5'd18, 4'd10, 35'h000000040, 18'h00000, 11'h000, 2'd0, 2'd1},
        // R8/R4: open hash cancels bank, row bit 6 <- a22
        '{1'b0, 1'b0, 1'b1, 5'd18, 4'd10, 35'h000440000, 18'h00040, 11'h000, 2'd0, 2'd0},
        // R7/R2: close hash bank group, row bit 4 <- a20
        '{1'b1, 1'b0, 1'b1, 5'd18, 4'd10, 35'h000100080, 18'h00010, 11'h400, 2'd0, 2'd3},
        // R6/R3: close, 8 rows, 3 columns
        '{1'b1, 1'b0, 1'b0, 5'd8,  4'd3,  35'h7FFFFFFFF, 18'h000FF, 11'h407, 2'd3, 2'd3},
        // R6: open, oversized counts clamp
        '{1'b0, 1'b0, 1'b0, 5'd31, 4'd15, 35'h7FFFFFFFF, 18'h3FFFF, 11'h3FF, 2'd3, 2'd3},
        // R6/R3: zero counts, auto-precharge stays
        '{1'b1, 1'b0, 1'b0, 5'd0,  4'd0,  35'h7FFFFFFFF, 18'h00000, 11'h400, 2'd3, 2'd3},
        // R8: open all ones with hash
        '{1'b0, 1'b0, 1'b1, 5'd18, 4'd10, 35'h7FFFFFFFF, 18'h3FFFF, 11'h3FF, 2'd0, 2'd0},
        // R6/R4: top row bit masked at 17 rows
        '{1'b0, 1'b0, 1'b0, 5'd17, 4'd10, 35'h400000000, 18'h00000, 11'h000, 2'd0, 2'd0},
        // R4: row bit 17 <- a34
        '{1'b0, 1'b0, 1'b0, 5'd18, 4'd10, 35'h400000000, 18'h20000, 11'h000, 2'd0, 2'd0},
        // R3: close column bit 3 <- a14
        '{1'b1, 1'b0, 1'b0, 5'd18, 4'd10, 35'h000004000, 18'h00000, 11'h408, 2'd0, 2'd0}
    };

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic vld);
        cfg_close_page = v.close;
        cfg_fine_bank  = v.fine;
        cfg_bank_xor   = v.hx;
        cfg_row_bits   = v.rb;
        cfg_col_bits   = v.cb;
        in_addr        = v.addr;
        in_vld         = vld;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        apply(VEC[0], 1'b1);
        repeat (3) @(negedge clk);
        // R9: reset state, even with in_vld held high
        check("R9 out_vld", 36'(out_vld), 36'd0);
        check("R9 out_row", 36'(out_row), 36'd0);
        check("R9 out_col", 36'(out_col), 36'd0);
        check("R9 bank/bgrp", 36'({out_bank, out_bgrp}), 36'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 36'(out_vld), 36'd0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k], 1'b1);
            @(negedge clk);
            check($sformatf("R1 valid v%0d", k), 36'(out_vld), 36'd1);
            check($sformatf("R2/R4/R6 row v%0d", k), 36'(out_row), 36'(VEC[k].row));
            check($sformatf("R3/R5/R6 col v%0d", k), 36'(out_col), 36'(VEC[k].col));
            check($sformatf("R7/R8 bank v%0d", k), 36'(out_bank), 36'(VEC[k].bank));
            check($sformatf("R7/R8 bgrp v%0d", k), 36'(out_bgrp), 36'(VEC[k].bg));
        end

        // R1: hold with in_vld low while inputs change
        apply(VEC[8], 1'b0);
        @(negedge clk);
        check("R1 valid low", 36'(out_vld), 36'd0);
        check("R1 row held", 36'(out_row), 36'(VEC[NV-1].row));
        check("R1 col held", 36'(out_col), 36'(VEC[NV-1].col));
        check("R1 bank held", 36'({out_bank, out_bgrp}),
              36'({VEC[NV-1].bank, VEC[NV-1].bg}));

        // R1: back-to-back valids update each cycle
        apply(VEC[8], 1'b1);
        @(negedge clk);
        apply(VEC[9], 1'b1);
        check("R1 b2b first row", 36'(out_row), 36'(VEC[8].row));
        @(negedge clk);
        check("R1 b2b second row", 36'(out_row), 36'(VEC[9].row));
        in_vld = 1'b0;

        // R9: reset in mid-run clears fields
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset col", 36'(out_col), 36'd0);
        check("R9 mid reset valid", 36'(out_vld), 36'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule